// File: doc/BRIEF.md
# Drawing Accelerator Terminate and Status Front End

This block is the host-facing control and status front end of a 2D drawing accelerator. The host writes and reads single bytes at offsets inside a 256-byte register window. The block holds a control byte with a terminate bit, four low setup bytes (one of them the sync-enable byte), a read-only status byte, and a bank of operation registers in the upper half of the window. The drawing engine, the memory datapath and the command queue are not part of the block. The only trace of the queue is one input that reports pending queued writes.

Setting the terminate bit starts a timed reset, and the host sees it as a busy flag in the status byte. The reset runs on the system clock for a set number of cycles, and the host polls the status byte until the flag drops. At that point the operation bank and most of the low setup bytes hold zero again. The terminate bit itself stays set until the host clears it. The usual host routine is: set terminate, poll status, clear terminate, clear sync-enable. The host may repeat this routine back to back.

Top module: `tacc_front`

## Requirements
- R1: After synchronous reset, every implemented byte (0x30, 0x31, 0x32, 0x34, 0x35, 0x80 to 0xFF) and the status byte 0x36 read 0x00.
- R2: Bytes 0x30, 0x31, 0x32, 0x34, 0x35 and the operation bank 0x80 to 0xFF store all 8 written bits. A read issued with rd_en returns its byte on rd_data, with rd_valid high, in the following cycle.
- R3: A reset sequence starts only when a write to 0x30 takes bit 4 from 0 to 1. Writing a value with bit 4 set while bit 4 is already 1 starts nothing and clears nothing.
- R4: Bit 1 of status byte 0x36 (reset busy) reads 1 for exactly RESET_CYCLES clocks after the clock edge that captured the starting write. After that it reads 0.
- R5: When the sequence ends, every operation register reads 0x00. Bytes 0x31, 0x32 and 0x34 read 0x00. Byte 0x35 has bits 7:5 cleared and keeps bits 4:0.
- R6: The end of the sequence leaves byte 0x30 unchanged, so bit 4 stays 1 until the host writes it to 0.
- R7: Bit 0 of 0x36 reflects the queue_pend input, and a terminate never sets it. Bits 7:2 of 0x36 always read 0.
- R8: A new 0-to-1 edge of bit 4 while a sequence is running restarts the count. Busy then lasts RESET_CYCLES clocks from the new edge.
- R9: Reads of offsets outside the implemented set (such as 0x00, 0x33, 0x7F) return 0x00. Writes to those offsets and to 0x36 have no effect.
- R10: A host write to an operation register while busy is stored and reads back. When the sequence ends, the clear overrides it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System (memory) clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host byte write strobe |
| wr_addr | input | 8 | Write offset in the register window |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Host byte read strobe |
| rd_addr | input | 8 | Read offset in the register window |
| rd_data | output | 8 | Read data, valid the cycle after rd_en |
| rd_valid | output | 1 | Marks rd_data as holding a read result |
| queue_pend | input | 1 | Queued writes pending, shown as status bit 0 |

## Verification
The bench builds the block with RESET_CYCLES set to 20 and keeps the default operation bank of 128 bytes at base 0x80. The short count lets the bench poll status on every clock through a whole busy window and predict each polled value. It also lets a second terminate edge land while the first sequence still has cycles left, which makes a missing restart visible as a busy window that ends too early. The default bank spans the window up to 0xFF, so the first, a middle and the last operation byte are all checked for storage and for clearing.

// File: rtl/tacc_pkg.sv
`timescale 1ns/1ps
package tacc_pkg;

    localparam int BYTE_W = 8;

    // Fixed offsets in the host window
    localparam logic [BYTE_W-1:0] OFS_CTRL = 8'h30;
    localparam logic [BYTE_W-1:0] OFS_AUX  = 8'h31;
    localparam logic [BYTE_W-1:0] OFS_SYNC = 8'h32;
    localparam logic [BYTE_W-1:0] OFS_MODE = 8'h34;
    localparam logic [BYTE_W-1:0] OFS_FMT  = 8'h35;
    localparam logic [BYTE_W-1:0] OFS_STAT = 8'h36;

    localparam int TERM_BIT = 4;

    // Bits of the format byte that the sequence clears
    localparam logic [BYTE_W-1:0] FMT_CLR_MASK = 8'hE0;

    typedef struct packed {
        logic              en;
        logic [BYTE_W-1:0] addr;
        logic [BYTE_W-1:0] data;
    } host_wr_t;

    typedef struct packed {
        logic [BYTE_W-1:0] ctrl;
        logic [BYTE_W-1:0] aux;
        logic [BYTE_W-1:0] sync;
        logic [BYTE_W-1:0] mode;
        logic [BYTE_W-1:0] fmt;
    } low_regs_t;

    function automatic logic [BYTE_W-1:0] status_byte(input logic wbusy, input logic rbusy);
        return {{(BYTE_W-2){1'b0}}, rbusy, wbusy};
    endfunction

endpackage

// File: rtl/tacc_term_seq.sv
`timescale 1ns/1ps
module tacc_term_seq #(
    parameter int unsigned CYCLES = 256
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy,
    output logic done
);
    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (start)
            cnt <= CW'(CYCLES);
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign busy = (cnt != '0);
    // The last busy cycle ends the sequence unless a new edge reloads it
    assign done = (cnt == CW'(1)) && !start;

    assert_busy_from_edge_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(start));

    assert_done_drops_R4: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy);

    assert_restart_busy_R8: assert property (@(posedge clk) disable iff (rst)
        start |=> busy);

endmodule

// File: rtl/tacc_ctl_regs.sv
`timescale 1ns/1ps
module tacc_ctl_regs
    import tacc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  host_wr_t  wr,
    input  logic      done,
    output low_regs_t regs,
    output logic      term_edge
);
    logic hit_ctrl, hit_aux, hit_sync, hit_mode, hit_fmt;

    assign hit_ctrl = wr.en && (wr.addr == OFS_CTRL);
    assign hit_aux  = wr.en && (wr.addr == OFS_AUX);
    assign hit_sync = wr.en && (wr.addr == OFS_SYNC);
    assign hit_mode = wr.en && (wr.addr == OFS_MODE);
    assign hit_fmt  = wr.en && (wr.addr == OFS_FMT);

    assign term_edge = hit_ctrl && wr.data[TERM_BIT] && !regs.ctrl[TERM_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            regs <= '0;
        end else begin
            // control byte is never touched by the sequence
            if (hit_ctrl) regs.ctrl <= wr.data;
            if (done) begin
                regs.aux  <= '0;
                regs.sync <= '0;
                regs.mode <= '0;
                regs.fmt  <= regs.fmt & ~FMT_CLR_MASK;
            end else begin
                if (hit_aux)  regs.aux  <= wr.data;
                if (hit_sync) regs.sync <= wr.data;
                if (hit_mode) regs.mode <= wr.data;
                if (hit_fmt)  regs.fmt  <= wr.data;
            end
        end
    end

    assert_ctrl_kept_R6: assert property (@(posedge clk) disable iff (rst)
        (done && !hit_ctrl) |=> $stable(regs.ctrl));

    assert_low_cleared_R5: assert property (@(posedge clk) disable iff (rst)
        done |=> (regs.aux == '0 && regs.sync == '0 && regs.mode == '0
                  && (regs.fmt & FMT_CLR_MASK) == '0));

    assert_fmt_low_kept_R5: assert property (@(posedge clk) disable iff (rst)
        done |=> (regs.fmt & ~FMT_CLR_MASK) == ($past(regs.fmt) & ~FMT_CLR_MASK));

endmodule

// File: rtl/tacc_op_bank.sv
`timescale 1ns/1ps
module tacc_op_bank
    import tacc_pkg::*;
#(
    parameter int unsigned BASE  = 128,
    parameter int unsigned COUNT = 128
) (
    input  logic              clk,
    input  logic              rst,
    input  host_wr_t          wr,
    input  logic              done,
    input  logic [BYTE_W-1:0] rd_addr,
    output logic [BYTE_W-1:0] rd_byte
);
    logic [BYTE_W-1:0] ops [COUNT];

    for (genvar g = 0; g < COUNT; g++) begin : g_op
        always_ff @(posedge clk) begin
            if (rst || done)
                ops[g] <= '0;
            else if (wr.en && wr.addr == BYTE_W'(BASE + g))
                ops[g] <= wr.data;
        end
    end

    always_comb begin
        rd_byte = '0;
        for (int i = 0; i < COUNT; i++)
            if (rd_addr == BYTE_W'(BASE + i)) rd_byte = ops[i];
    end

    logic any_nz;
    always_comb begin
        any_nz = 1'b0;
        for (int i = 0; i < COUNT; i++)
            any_nz = any_nz | (ops[i] != '0);
    end

    assert_ops_zero_R5: assert property (@(posedge clk) disable iff (rst)
        done |=> !any_nz);

endmodule

// File: rtl/tacc_front.sv
`timescale 1ns/1ps
module tacc_front
    import tacc_pkg::*;
#(
    parameter int unsigned RESET_CYCLES = 256,
    parameter int unsigned OP_BASE      = 128,
    parameter int unsigned OP_COUNT     = 128
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [7:0] wr_addr,
    input  logic [7:0] wr_data,
    input  logic       rd_en,
    input  logic [7:0] rd_addr,
    output logic [7:0] rd_data,
    output logic       rd_valid,
    input  logic       queue_pend
);
    host_wr_t          wr;
    low_regs_t         low;
    logic              term_edge, busy, done;
    logic [BYTE_W-1:0] op_byte, rd_next;

    assign wr = '{en: wr_en, addr: wr_addr, data: wr_data};

    tacc_ctl_regs u_ctl (
        .clk(clk), .rst(rst), .wr(wr), .done(done),
        .regs(low), .term_edge(term_edge)
    );

    tacc_term_seq #(.CYCLES(RESET_CYCLES)) u_seq (
        .clk(clk), .rst(rst), .start(term_edge), .busy(busy), .done(done)
    );

    tacc_op_bank #(.BASE(OP_BASE), .COUNT(OP_COUNT)) u_ops (
        .clk(clk), .rst(rst), .wr(wr), .done(done),
        .rd_addr(rd_addr), .rd_byte(op_byte)
    );

    always_comb begin
        case (rd_addr)
            OFS_CTRL: rd_next = low.ctrl;
            OFS_AUX:  rd_next = low.aux;
            OFS_SYNC: rd_next = low.sync;
            OFS_MODE: rd_next = low.mode;
            OFS_FMT:  rd_next = low.fmt;
            OFS_STAT: rd_next = status_byte(queue_pend, busy);
            default:  rd_next = op_byte;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en) rd_data <= rd_next;
        end
    end

    assert_rd_valid_R2: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> rd_valid);

    assert_stat_high_zero_R7: assert property (@(posedge clk) disable iff (rst)
        (rd_en && rd_addr == OFS_STAT) |=> rd_data[7:2] == 6'd0);

    assert_wbusy_mirror_R7: assert property (@(posedge clk) disable iff (rst)
        (rd_en && rd_addr == OFS_STAT) |=> rd_data[0] == $past(queue_pend));

    assert_hole_reads_zero_R9: assert property (@(posedge clk) disable iff (rst)
        (rd_en && (rd_addr == 8'h33 || rd_addr == 8'h00)) |=> rd_data == 8'h00);

endmodule

// File: tb/sim_tacc_front.sv
`timescale 1ns/1ps
module sim_tacc_front;
    localparam int N = 20;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0, rd_en = 1'b0, queue_pend = 1'b0;
    logic [7:0] wr_addr = '0, wr_data = '0, rd_addr = '0;
    logic [7:0] rd_data;
    logic       rd_valid;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    logic [7:0] exp_q [$];
    string      tag_q [$];

    always #5 clk = ~clk;

    tacc_front #(.RESET_CYCLES(N), .OP_BASE(128), .OP_COUNT(128)) u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .rd_valid(rd_valid),
        .queue_pend(queue_pend)
    );

    // monitor: pops expected items as read results appear
    always @(negedge clk) begin
        if (!rst && rd_valid) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R2 unexpected read result: actual %02h expected none", rd_data);
            end else begin
                automatic logic [7:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                if (rd_data !== e) begin
                    errors++;
                    $display("FAIL %s: actual %02h expected %02h", t, rd_data, e);
                end
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [7:0] e, input string t);
        rd_en = 1'b1; rd_addr = a;
        exp_q.push_back(e); tag_q.push_back(t);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run;
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(150000 * 10);
        errors++;
        $display("FAIL watchdog: actual hung expected completion");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        idle(1);

        // R1 reset values
        rd(8'h30, 8'h00, "R1 ctrl");
        rd(8'h31, 8'h00, "R1 aux");
        rd(8'h32, 8'h00, "R1 sync");
        rd(8'h34, 8'h00, "R1 mode");
        rd(8'h35, 8'h00, "R1 fmt");
        rd(8'h36, 8'h00, "R1 status");
        rd(8'h80, 8'h00, "R1 op first");
        rd(8'hFF, 8'h00, "R1 op last");

        // R2 storage
        wr(8'h31, 8'hA5); wr(8'h32, 8'h3C); wr(8'h34, 8'h7E); wr(8'h35, 8'hFF);
        wr(8'h80, 8'h11); wr(8'hC3, 8'h5A); wr(8'hFF, 8'hEE); wr(8'h30, 8'h01);
        rd(8'h31, 8'hA5, "R2 aux");
        rd(8'h32, 8'h3C, "R2 sync");
        rd(8'h34, 8'h7E, "R2 mode");
        rd(8'h35, 8'hFF, "R2 fmt");
        rd(8'h80, 8'h11, "R2 op 0x80");
        rd(8'hC3, 8'h5A, "R2 op 0xC3");
        rd(8'hFF, 8'hEE, "R2 op 0xFF");
        rd(8'h30, 8'h01, "R2 ctrl");

        // R9 holes
        wr(8'h33, 8'h77); wr(8'h36, 8'hFF); wr(8'h00, 8'h12); wr(8'h7F, 8'h34);
        rd(8'h33, 8'h00, "R9 hole 0x33");
        rd(8'h00, 8'h00, "R9 hole 0x00");
        rd(8'h7F, 8'h00, "R9 hole 0x7F");
        rd(8'h36, 8'h00, "R9 status write ignored");
        rd(8'h80, 8'h11, "R9 neighbour intact");

        // R7 queue pending mirror
        queue_pend = 1'b1;
        rd(8'h36, 8'h01, "R7 wbusy set");
        queue_pend = 1'b0;
        rd(8'h36, 8'h00, "R7 wbusy clear");

        // R4 exact busy window, R7 terminate does not raise bit 0
        wr(8'h30, 8'h11);
        for (int i = 0; i < N; i++) rd(8'h36, 8'h02, "R4 busy poll");
        rd(8'h36, 8'h00, "R4 busy dropped");
        rd(8'h36, 8'h00, "R4 stays idle");

        // R5 clearing, R6 control kept
        rd(8'h80, 8'h00, "R5 op 0x80");
        rd(8'hC3, 8'h00, "R5 op 0xC3");
        rd(8'hFF, 8'h00, "R5 op 0xFF");
        rd(8'h31, 8'h00, "R5 aux");
        rd(8'h32, 8'h00, "R5 sync");
        rd(8'h34, 8'h00, "R5 mode");
        rd(8'h35, 8'h1F, "R5 fmt low bits kept");
        rd(8'h30, 8'h11, "R6 ctrl kept");

        // R3 no edge when bit 4 already set
        wr(8'h80, 8'h55);
        wr(8'h30, 8'h10);
        rd(8'h36, 8'h00, "R3 no start");
        idle(N + 2);
        rd(8'h80, 8'h55, "R3 no clear");

        // R8 host routine back to back, second edge restarts
        wr(8'h30, 8'h00);
        wr(8'h30, 8'h10);
        rd(8'h36, 8'h02, "R8 first run busy");
        rd(8'h36, 8'h02, "R8 first run busy");
        rd(8'h36, 8'h02, "R8 first run busy");
        wr(8'h30, 8'h00);
        wr(8'h32, 8'h00);
        queue_pend = 1'b1;
        wr(8'h30, 8'h10);
        for (int i = 0; i < N; i++) rd(8'h36, 8'h03, "R8 restarted busy");
        rd(8'h36, 8'h01, "R8 done, R7 bit0 kept");
        queue_pend = 1'b0;
        rd(8'h80, 8'h00, "R8 ops cleared");

        // R10 write during busy, cleared at end
        wr(8'h30, 8'h00);
        wr(8'h30, 8'h10);
        wr(8'h90, 8'h66);
        rd(8'h90, 8'h66, "R10 stored while busy");
        idle(N + 2);
        rd(8'h90, 8'h00, "R10 cleared at end");
        rd(8'h30, 8'h10, "R6 terminate bit kept");

        idle(3);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R2 missing read results: actual %0d pending expected 0", exp_q.size());
        end
        finish_run();
    end
endmodule